// File: doc/BRIEF.md
# Inbound DMA Memory Window Decoder

This block sits on the inbound side of a host bridge. It checks each address a bus master presents against a small set of programmable memory windows. Only cycles that fall inside one of those windows reach system memory. Each window is one 32-bit register. The register packs a base address, aligned to 1 MB, together with a 4-bit logarithmic size code. Local memory begins at address zero, so translation is just the inbound address minus the window base.

Inbound addresses arrive on a valid/ready stream. Each result leaves on a second valid/ready stream and carries three fields: a hit flag, the index of the matching window and the translated address. One output register separates the two streams. That register takes a new address whenever it is empty or its contents are being consumed in the same cycle. The input is stalled only while a result is waiting and `out_ready` is low. While stalled, the result is held unchanged. Software programs and reads the windows through a plain write/read port. Reads are combinational.

Top module: `dmawin_decoder`

## Requirements
- R1: The window registers sit at byte offsets 0x50, 0x54 and 0x58, for windows 0, 1 and 2. A write stores bits 31:16. A read returns them, with bits 15:0 always zero. Reads at any other offset return zero, and writes there change no window.
- R2: Bits 31:20 hold the window base (1 MB aligned). Bits 19:16 hold size code c, and for c from 0 to 11 the window spans 2^(20+c) bytes (0 gives 1 MB, 11 gives 2 GB).
- R3: A window with a valid code hits when base <= address < base + size. This comparison uses at least 33 bits, so a window ending exactly at 4 GB includes address 0xFFFFFFFF.
- R4: A window whose size code is 12 to 15 never hits.
- R5: When several windows hit, the lowest-numbered one is reported.
- R6: On a hit, `out_hit` is 1, `out_win` is the window index and `out_addr` is the address minus that window's base.
- R7: On a miss, `out_hit` is 0, `out_win` is 0 and `out_addr` equals the inbound address.
- R8: `in_ready` equals `!out_valid || out_ready`. An accepted address yields `out_valid` and its result on the next clock edge. While `out_valid && !out_ready`, all output fields hold steady.
- R9: Reset clears all window registers to zero and drops `out_valid`.
- R10: An address accepted in the same cycle as a register write is decoded with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at `cfg_addr` |
| in_valid | input | 1 | Inbound address valid |
| in_ready | output | 1 | Decoder can accept an address |
| in_addr | input | 32 | Inbound bus-master address |
| out_valid | output | 1 | Decode result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_hit | output | 1 | Address fell in an enabled window |
| out_win | output | 2 | Index of the winning window |
| out_addr | output | 32 | Translated (or passed-through) address |

## Verification
Decode results are due exactly one clock edge after the cycle in which `in_valid && in_ready` holds. Register contents are visible on `cfg_rdata` right after the edge that writes them. `in_ready` is combinational in the same cycle.

A behavioural model in the bench updates on the same edge and compares every output at the following falling edge. Directed stimuli are driven at a falling edge and checked at the next one. This places each check one edge after acceptance. The stall case compares held outputs across several cycles with `out_ready` low.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
  localparam int ADDR_W   = 32;  // address and register width
  localparam int BASE_LSB = 20;  // 1 MB base granularity
  localparam int CODE_W   = 4;   // size code width
  localparam int CODE_MAX = 11;  // largest code that enables a window
  localparam int CFG_AW   = 8;   // register offset width
  localparam int NUM_WIN  = 3;   // number of windows
endpackage

// File: rtl/dmawin_regs.sv
module dmawin_regs #(
  parameter int ADDR_W   = dmawin_pkg::ADDR_W,
  parameter int BASE_LSB = dmawin_pkg::BASE_LSB,
  parameter int CODE_W   = dmawin_pkg::CODE_W,
  parameter int CFG_AW   = dmawin_pkg::CFG_AW,
  parameter int NUM_WIN  = dmawin_pkg::NUM_WIN,
  parameter int REG_BASE = 'h50
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [ADDR_W-1:0]        cfg_wdata,
  output logic [ADDR_W-1:0]        cfg_rdata,
  output logic [ADDR_W-CODE_LSB_P(BASE_LSB,CODE_W)-1:0] fld [NUM_WIN]
);
  function automatic int CODE_LSB_P(input int b, input int c);
    return b - c;
  endfunction

  localparam int CODE_LSB = BASE_LSB - CODE_W;
  localparam int FLD_W    = ADDR_W - CODE_LSB;

  logic [NUM_WIN-1:0] sel;
  logic [FLD_W-1:0]   store_q [NUM_WIN];
  logic               unused_low;

  assign unused_low = ^cfg_wdata[CODE_LSB-1:0];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [CFG_AW-1:0] OFS = CFG_AW'(REG_BASE + 4 * i);
    assign sel[i] = (cfg_addr == OFS);

    always_ff @(posedge clk) begin
      if (!rst_n)                store_q[i] <= '0;
      else if (cfg_we && sel[i]) store_q[i] <= cfg_wdata[ADDR_W-1:CODE_LSB];
    end
    assign fld[i] = store_q[i];
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (sel[i]) cfg_rdata = {store_q[i], {CODE_LSB{1'b0}}};
  end

  AST_STRAY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sel == '0) |=> (fld[0] == $past(fld[0]))); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $rose(rst_n) |-> (fld[0] == '0)); // R9
endmodule

// File: rtl/dmawin_match.sv
module dmawin_match #(
  parameter int ADDR_W   = dmawin_pkg::ADDR_W,
  parameter int BASE_LSB = dmawin_pkg::BASE_LSB,
  parameter int CODE_W   = dmawin_pkg::CODE_W,
  parameter int CODE_MAX = dmawin_pkg::CODE_MAX
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [ADDR_W-BASE_LSB+CODE_W-1:0]   fld,
  output logic                                hit,
  output logic [ADDR_W-1:0]                   offset
);
  localparam int BASE_W = ADDR_W - BASE_LSB;

  logic [CODE_W-1:0] code;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   limit;
  logic              enabled;

  assign code    = fld[CODE_W-1:0];
  assign base    = {fld[CODE_W +: BASE_W], {BASE_LSB{1'b0}}};
  assign enabled = (int'(code) <= CODE_MAX);
  assign span    = enabled ? ({{ADDR_W{1'b0}}, 1'b1} << (int'(code) + BASE_LSB)) : '0;
  assign limit   = {1'b0, base} + span;
  assign hit     = enabled && (addr >= base) && ({1'b0, addr} < limit);
  assign offset  = addr - base;

  always_comb begin
    if (hit) AST_OFFSET_IN_SPAN: assert ({1'b0, offset} < span); // R3
  end
endmodule

// File: rtl/dmawin_prio.sv
module dmawin_prio #(
  parameter int ADDR_W  = dmawin_pkg::ADDR_W,
  parameter int NUM_WIN = dmawin_pkg::NUM_WIN,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  input  logic [ADDR_W-1:0]  offs [NUM_WIN],
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [IDX_W-1:0]   win,
  output logic [ADDR_W-1:0]  taddr
);
  always_comb begin
    hit   = 1'b0;
    win   = '0;
    taddr = addr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit   = 1'b1;
        win   = IDX_W'(i);
        taddr = offs[i];
      end
    end
  end

  always_comb begin
    if (hit) begin
      AST_WINNER_HITS: assert (hit_vec[win]); // R5
      AST_NONE_LOWER: assert ((hit_vec & ((NUM_WIN'(1) << win) - NUM_WIN'(1))) == '0); // R5
    end
  end
endmodule

// File: rtl/dmawin_decoder.sv
module dmawin_decoder #(
  parameter int ADDR_W   = dmawin_pkg::ADDR_W,
  parameter int BASE_LSB = dmawin_pkg::BASE_LSB,
  parameter int CODE_W   = dmawin_pkg::CODE_W,
  parameter int CODE_MAX = dmawin_pkg::CODE_MAX,
  parameter int CFG_AW   = dmawin_pkg::CFG_AW,
  parameter int NUM_WIN  = dmawin_pkg::NUM_WIN,
  parameter int REG_BASE = 'h50,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_win,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int FLD_W = ADDR_W - BASE_LSB + CODE_W;

  logic [FLD_W-1:0]   fld [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic [ADDR_W-1:0]  offs [NUM_WIN];
  logic               d_hit;
  logic [IDX_W-1:0]   d_win;
  logic [ADDR_W-1:0]  d_addr;
  logic               take;

  dmawin_regs #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W),
    .CFG_AW(CFG_AW), .NUM_WIN(NUM_WIN), .REG_BASE(REG_BASE)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fld(fld)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    dmawin_match #(
      .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX)
    ) match_i (
      .addr(in_addr), .fld(fld[i]), .hit(hit_vec[i]), .offset(offs[i])
    );
  end

  dmawin_prio #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) prio_i (
    .hit_vec(hit_vec), .offs(offs), .addr(in_addr),
    .hit(d_hit), .win(d_win), .taddr(d_addr)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_win   <= '0;
      out_addr  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_hit   <= d_hit;
      out_win   <= d_win;
      out_addr  <= d_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_win) && $stable(out_addr))); // R8
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_win == '0)); // R7
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_win) < NUM_WIN)); // R6
endmodule

// File: tb/dmawin_decoder_tb.sv
module dmawin_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit;
  logic [1:0]  out_win;
  logic [31:0] out_addr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dmawin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_hit(out_hit), .out_win(out_win),
    .out_addr(out_addr)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_reg [3];
  bit          m_valid;
  bit          m_hit;
  int          m_win;
  logic [31:0] m_addr;

  function automatic void ref_dec(input logic [31:0] a, output bit h,
                                  output int w, output logic [31:0] t);
    h = 0; w = 0; t = a;
    for (int i = 2; i >= 0; i--) begin
      int code = int'(m_reg[i][19:16]);
      if (code <= 11) begin
        longint unsigned b  = longint'(m_reg[i] & 32'hFFF0_0000);
        longint unsigned sz = longint'(1) << (20 + code);
        if (longint'(a) >= b && longint'(a) < b + sz) begin
          h = 1; w = i; t = a - 32'(b);
        end
      end
    end
  endfunction

  function automatic logic [31:0] ref_read(input logic [7:0] o);
    for (int i = 0; i < 3; i++)
      if (o == 8'(8'h50 + 4 * i)) return m_reg[i];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_reg[i] <= '0;
      m_valid <= 0; m_hit <= 0; m_win <= 0; m_addr <= '0;
    end else begin
      if (in_valid && (!m_valid || out_ready)) begin
        bit h; int w; logic [31:0] t;
        ref_dec(in_addr, h, w, t);
        m_valid <= 1; m_hit <= h; m_win <= w; m_addr <= t;
      end else if (out_ready) begin
        m_valid <= 0;
      end
      if (cfg_we)
        for (int i = 0; i < 3; i++)
          if (cfg_addr == 8'(8'h50 + 4 * i)) m_reg[i] <= cfg_wdata & 32'hFFFF_0000;
    end
  end

  // compare on every falling edge after reset
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== (!m_valid || out_ready) || out_valid !== m_valid ||
          (m_valid && (out_hit !== m_hit || int'(out_win) != m_win || out_addr !== m_addr)) ||
          cfg_rdata !== ref_read(cfg_addr)) begin
        errors++;
        $display("FAIL R8 model compare: act v=%0b h=%0b w=%0d a=%08h rd=%08h exp v=%0b h=%0b w=%0d a=%08h rd=%08h",
                 out_valid, out_hit, out_win, out_addr, cfg_rdata,
                 m_valid, m_hit, m_win, m_addr, ref_read(cfg_addr));
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL R8 watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] o, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = o; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [7:0] o, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_addr = o; #1;
    chk(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  task automatic send(input logic [31:0] a, input bit h, input int w,
                      input logic [31:0] t, input string tag);
    @(negedge clk); in_valid = 1; in_addr = a;
    @(negedge clk); in_valid = 0;
    chk(out_valid === 1'b1 && out_hit === h && int'(out_win) == w && out_addr === t,
        tag, out_addr, t);
    chk(out_hit === h && int'(out_win) == w, {tag, " hit/win"}, {30'd0, out_win} | (32'(out_hit) << 8),
        32'(w) | (32'(h) << 8));
  endtask

  logic [31:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 reset outputs", 32'(out_valid), 0);
    rd(8'h50, 32'h0, "R9 reset window0");
    rd(8'h58, 32'h0, "R9 reset window2");

    // R1 register port
    wr(8'h50, 32'h0007_ABCD);
    rd(8'h50, 32'h0007_0000, "R1 reserved bits read zero");
    wr(8'h54, 32'h1006_0000);
    wr(8'h58, 32'h0C0F_0000);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h0, "R1 unmapped offset reads zero");
    rd(8'h54, 32'h1006_0000, "R1 stray write leaves window1");
    rd(8'h58, 32'h0C0F_0000, "R1 readback window2");

    // R3 / R6 / R7 edges
    send(32'h07FF_FFFF, 1, 0, 32'h07FF_FFFF, "R3 last byte of 128MB window");
    send(32'h0800_0000, 0, 0, 32'h0800_0000, "R7 miss just past window0");
    send(32'h1000_0004, 1, 1, 32'h0000_0004, "R6 translate window1");
    send(32'h13FF_FFFF, 1, 1, 32'h03FF_FFFF, "R3 top of 64MB window1");
    send(32'h1400_0000, 0, 0, 32'h1400_0000, "R3 end of window1 misses");

    // R4 disabled code, then R2 smallest size
    send(32'h0C00_0000, 0, 0, 32'h0C00_0000, "R4 code 0xF never hits");
    wr(8'h58, 32'h0C00_0000);
    send(32'h0C00_0010, 1, 2, 32'h0000_0010, "R2 code 0 1MB window2");
    send(32'h0C10_0000, 0, 0, 32'h0C10_0000, "R2 1MB limit");

    // R5 priority
    wr(8'h54, 32'h0000_0000);
    send(32'h0000_0100, 1, 0, 32'h0000_0100, "R5 lowest window wins");
    wr(8'h50, 32'h000F_0000);
    send(32'h0000_0100, 1, 1, 32'h0000_0100, "R5 next window after disable");

    // R2 2GB window reaching 4GB
    wr(8'h50, 32'h800B_0000);
    send(32'hFFFF_FFFF, 1, 0, 32'h7FFF_FFFF, "R2 2GB window top address");
    send(32'h7FFF_FFFF, 0, 0, 32'h7FFF_FFFF, "R3 below 2GB base misses");

    // R10 same-cycle write
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h50; cfg_wdata = 32'h000F_0000;
    in_valid = 1; in_addr = 32'h8000_0000;
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    chk(out_hit === 1'b1 && out_win === 2'd0 && out_addr === 32'h0, "R10 old registers decode", out_addr, 0);
    send(32'h8000_0000, 0, 0, 32'h8000_0000, "R10 new registers apply");

    // R8 back-pressure
    wr(8'h50, 32'h2003_0000);
    @(negedge clk); out_ready = 0; in_valid = 1; in_addr = 32'h2000_0040;
    @(negedge clk); in_addr = 32'h2000_0080;
    held = out_addr;
    chk(out_valid === 1'b1 && in_ready === 1'b0, "R8 stall drops in_ready", 32'(in_ready), 0);
    chk(held === 32'h0000_0040, "R8 first result", held, 32'h40);
    repeat (3) @(negedge clk);
    chk(out_addr === held && out_valid === 1'b1, "R8 held while stalled", out_addr, held);
    out_ready = 1;
    @(negedge clk); in_valid = 0;
    chk(out_addr === 32'h0000_0080 && out_valid === 1'b1, "R8 pending address accepted", out_addr, 32'h80);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 drains", 32'(out_valid), 0);

    // random traffic against the model (R3 R5 R6 R7 R8 R10)
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      in_valid  = ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 3))
        0: in_addr = $urandom;
        1: in_addr = (m_reg[$urandom_range(0, 2)] & 32'hFFF0_0000) + 32'($urandom_range(0, 3)) - 32'd1;
        default: begin
          int k = $urandom_range(0, 2);
          int c = int'(m_reg[k][19:16]);
          in_addr = (m_reg[k] & 32'hFFF0_0000) + ((c <= 11) ? (32'd1 << (20 + c)) : 32'd0)
                    + 32'($urandom_range(0, 2)) - 32'd1;
        end
      endcase
      cfg_we = ($urandom_range(0, 24) == 0);
      cfg_addr = 8'h4C + 8'(4 * $urandom_range(0, 4));
      cfg_wdata = {$urandom_range(0, 4095) >> $urandom_range(0, 11), 4'($urandom_range(0, 15)), 16'($urandom)};
      cfg_wdata[31:20] = 12'($urandom_range(0, 15) << 8);
    end
    @(negedge clk); in_valid = 0; cfg_we = 0; out_ready = 1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule